// File: doc/BRIEF.md
# Multi-Mode System Timer Unit

This block keeps three timers and a prescaler behind a 32-bit register bus. The tick timer is a free-running 32-bit up-counter. It advances on each pulse of a slow periodic tick, a nominal 60 Hz strobe, and reports every tick as a one-cycle request. The prescaled timer is a 16-bit down-counter. Its steps come from the prescaler, which divides the block clock into periods of a programmable number of microseconds. The fast timer is a 30-bit down-counter that steps on a fast strobe, nominally 12.5 MHz. Both strobes are produced outside the block and arrive as one-cycle enables in the block clock domain.

Both down-counters share one controller built around two states, Idle and Run. The controller has four transitions:
- A start write moves Idle to Run. It loads a count and has its start bit set.
- A stop write moves Run to Idle. It loads a count with the start bit clear.
- A reload write keeps Run. It loads a new count with the start bit set.
- Expiry moves Run to Idle. It happens on the step that brings the count to zero, latches the expired flag and sends one pulse to the interrupt controller.

Each register read returns the live count, the running bit and the expired flag.

Top module: `systick_unit`

## Requirements
- R1: After reset, every register reads 0 and all three request outputs are low.
- R2: Byte offset 0x8C holds the tick timer.
  - Each cycle with `tick_60hz` high adds 1 to it.
  - Each such tick raises `irq_tick` for exactly the following cycle.
  - A write loads all 32 bits.
- R3: Byte offset 0x88 holds the prescaler value P.
  - While P is nonzero, a step goes to the prescaled timer every P*CLK_PER_US clock cycles.
  - The phase restarts on any write to 0x88 or 0x90.
  - P = 0 produces no steps.
- R4: Byte offset 0x90 holds the prescaled timer, with count in bits 15:0, running in bit 16 and expired in bit 17. Bits 31:18 read 0.
  - A write loads bits 15:0 and clears expired.
  - The timer is left running only if written bit 16 is 1.
- R5: A running prescaled timer decrements by one per step.
  - On the step that reaches zero it stops at count 0 and sets bit 17.
  - It raises `irq_t1` for exactly one cycle, the cycle after that step.
- R6: Byte offset 0xA8 holds the fast timer, with count in bits 29:0, running in bit 30 and expired in bit 31.
  - A write loads bits 29:0 and clears expired.
  - It runs the timer if bit 30 is 1 and stops it otherwise.
- R7: A running fast timer decrements once per cycle with `tick_fast` high.
  - On reaching zero it stops, sets bit 31 and raises `irq_t3` for one cycle, the cycle after that step.
- R8: A down-counter started with count 0 expires on its first step.
- R9: Reads of any other offset return 0. Writes to any other offset change no register.
- R10: A register write in the same cycle as a step or tick for that timer takes effect, and the step or tick is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the prescaler reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tick_60hz | input | 1 | One-cycle slow tick enable |
| tick_fast | input | 1 | One-cycle fast tick enable |
| irq_tick | output | 1 | Pulse for each slow tick |
| irq_t1 | output | 1 | Prescaled timer expiry pulse |
| irq_t3 | output | 1 | Fast timer expiry pulse |

## Verification
A write is visible on `reg_rdata` in the cycle after the clock edge that takes it, and a tick request comes one cycle after its tick. The prescaled timer loaded with N (N greater than zero) expires N*P*CLK_PER_US cycles after its write edge, and the fast timer expires one cycle after its Nth fast strobe. The bench drives inputs and samples outputs on the falling edge. A bench reference model, advanced on the rising edge from the same inputs, gives the expected values for the directed sequences and for seeded random traffic, so each compare falls in the cycle where its result is due.

// File: rtl/systick_pkg.sv
package systick_pkg;

    typedef enum logic {
        TS_IDLE = 1'b0,
        TS_RUN  = 1'b1
    } tmr_state_e;

    localparam int unsigned REG_ADDR_W = 8;

    localparam logic [REG_ADDR_W-1:0] OFF_PRESC = 8'h88;
    localparam logic [REG_ADDR_W-1:0] OFF_TICK  = 8'h8C;
    localparam logic [REG_ADDR_W-1:0] OFF_PTMR  = 8'h90;
    localparam logic [REG_ADDR_W-1:0] OFF_FTMR  = 8'hA8;

endpackage

// File: rtl/systick_presc.sv
module systick_presc #(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned CLK_PER_US = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_presc,
    input  logic [DATA_W-1:0] presc_wdata,
    input  logic              restart,
    output logic [DATA_W-1:0] presc_q,
    output logic              step
);
    localparam int unsigned MUL_W = $clog2(CLK_PER_US + 1);
    localparam int unsigned PC_W  = DATA_W + MUL_W;

    logic [PC_W-1:0] phase_q;
    logic [PC_W-1:0] period;

    assign period = PC_W'(presc_q) * PC_W'(CLK_PER_US);
    assign step   = (presc_q != '0) && (phase_q == period - PC_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= '0;
            phase_q <= '0;
        end else begin
            if (wr_presc) begin
                presc_q <= presc_wdata;
            end
            if (wr_presc || restart || step || presc_q == '0) begin
                phase_q <= '0;
            end else begin
                phase_q <= phase_q + PC_W'(1);
            end
        end
    end

endmodule

// File: rtl/systick_down.sv
module systick_down #(
    parameter int unsigned COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [COUNT_W:0]   wdata,
    input  logic               step,
    output logic [COUNT_W+1:0] rd_val,
    output logic               irq
);
    import systick_pkg::*;

    tmr_state_e         state_q, state_d;
    logic [COUNT_W-1:0] cnt_q;
    logic               exp_q;
    logic               irq_q;
    logic               expiring;

    assign expiring = (state_q == TS_RUN) && step && !wr && (cnt_q <= COUNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_IDLE: if (wr && wdata[COUNT_W]) state_d = TS_RUN;
            TS_RUN: begin
                if (wr)            state_d = wdata[COUNT_W] ? TS_RUN : TS_IDLE;
                else if (expiring) state_d = TS_IDLE;
            end
            default: state_d = TS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= expiring;
            if (wr) begin
                cnt_q <= wdata[COUNT_W-1:0];
                exp_q <= 1'b0;
            end else if (expiring) begin
                cnt_q <= '0;
                exp_q <= 1'b1;
            end else if (state_q == TS_RUN && step) begin
                cnt_q <= cnt_q - COUNT_W'(1);
            end
        end
    end

    assign rd_val = {exp_q, state_q == TS_RUN, cnt_q};
    assign irq    = irq_q;

endmodule

// File: rtl/systick_upcnt.sv
module systick_upcnt #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         tick,
    output logic [W-1:0] val,
    output logic         irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val <= '0;
            irq <= 1'b0;
        end else begin
            irq <= tick;
            if (wr)        val <= wdata;
            else if (tick) val <= val + W'(1);
        end
    end
endmodule

// File: rtl/systick_unit.sv
module systick_unit #(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned CLK_PER_US = 4,
    parameter int unsigned T1_W       = 16,
    parameter int unsigned T3_W       = 30
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                reg_wr,
    input  logic [systick_pkg::REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]                   reg_wdata,
    output logic [DATA_W-1:0]                   reg_rdata,
    input  logic                                tick_60hz,
    input  logic                                tick_fast,
    output logic                                irq_tick,
    output logic                                irq_t1,
    output logic                                irq_t3
);
    import systick_pkg::*;

    logic              sel_presc, sel_tick, sel_ptmr, sel_ftmr;
    logic [DATA_W-1:0] presc_val, t0_val;
    logic [T1_W+1:0]   t1_val;
    logic [T3_W+1:0]   t3_val;
    logic              t1_step;

    assign sel_presc = (reg_addr == OFF_PRESC);
    assign sel_tick  = (reg_addr == OFF_TICK);
    assign sel_ptmr  = (reg_addr == OFF_PTMR);
    assign sel_ftmr  = (reg_addr == OFF_FTMR);

    systick_presc #(.DATA_W(DATA_W), .CLK_PER_US(CLK_PER_US)) u_presc (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_presc   (reg_wr && sel_presc),
        .presc_wdata(reg_wdata),
        .restart    (reg_wr && sel_ptmr),
        .presc_q    (presc_val),
        .step       (t1_step)
    );

    systick_upcnt #(.W(DATA_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (reg_wr && sel_tick),
        .wdata(reg_wdata),
        .tick (tick_60hz),
        .val  (t0_val),
        .irq  (irq_tick)
    );

    systick_down #(.COUNT_W(T1_W)) u_ptmr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr && sel_ptmr),
        .wdata (reg_wdata[T1_W:0]),
        .step  (t1_step),
        .rd_val(t1_val),
        .irq   (irq_t1)
    );

    systick_down #(.COUNT_W(T3_W)) u_ftmr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr && sel_ftmr),
        .wdata (reg_wdata[T3_W:0]),
        .step  (tick_fast),
        .rd_val(t3_val),
        .irq   (irq_t3)
    );

    always_comb begin
        if (sel_presc)     reg_rdata = presc_val;
        else if (sel_tick) reg_rdata = t0_val;
        else if (sel_ptmr) reg_rdata = DATA_W'(t1_val);
        else if (sel_ftmr) reg_rdata = DATA_W'(t3_val);
        else               reg_rdata = '0;
    end

endmodule

// File: rtl/systick_unit_chk.sv
module systick_unit_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned T1_W   = 16,
    parameter int unsigned T3_W   = 30
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                reg_wr,
    input logic [systick_pkg::REG_ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0]                   reg_wdata,
    input logic                                tick_60hz,
    input logic                                tick_fast,
    input logic                                irq_tick,
    input logic                                irq_t1,
    input logic                                irq_t3,
    input logic [DATA_W-1:0]                   t0_val,
    input logic [T1_W+1:0]                     t1_val,
    input logic [T3_W+1:0]                     t3_val
);
    import systick_pkg::*;

    p_tick_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_60hz && !(reg_wr && reg_addr == OFF_TICK)
        |=> irq_tick && (t0_val == $past(t0_val) + DATA_W'(1)));

    p_t1_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == OFF_PTMR
        |=> (t1_val[T1_W-1:0] == $past(reg_wdata[T1_W-1:0])) && !t1_val[T1_W+1]
            && (t1_val[T1_W] == $past(reg_wdata[T1_W])));

    p_t1_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_t1 |-> t1_val[T1_W+1] && !t1_val[T1_W] && (t1_val[T1_W-1:0] == '0));

    p_t1_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_t1 |=> !irq_t1);

    p_t3_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == OFF_FTMR && !reg_wdata[T3_W]
        |=> !t3_val[T3_W] && (t3_val[T3_W-1:0] == $past(reg_wdata[T3_W-1:0])));

    p_t3_expire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_t3 |-> t3_val[T3_W+1] && !t3_val[T3_W] && (t3_val[T3_W-1:0] == '0));

    p_t3_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_fast && !reg_wr |=> $stable(t3_val));

endmodule

bind systick_unit systick_unit_chk #(.DATA_W(DATA_W), .T1_W(T1_W), .T3_W(T3_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .tick_60hz(tick_60hz),
    .tick_fast(tick_fast),
    .irq_tick (irq_tick),
    .irq_t1   (irq_t1),
    .irq_t3   (irq_t3),
    .t0_val   (t0_val),
    .t1_val   (t1_val),
    .t3_val   (t3_val)
);

// File: tb/systick_unit_tb.sv
module systick_unit_tb;
    localparam int unsigned CPU = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = 32'h0;
    logic        t60 = 1'b0;
    logic        ft = 1'b0;
    logic [31:0] rdata;
    logic        irq0, irq1, irq3;

    int tests = 0;
    int fails = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    systick_unit #(.CLK_PER_US(CPU)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .tick_60hz(t60), .tick_fast(ft),
        .irq_tick(irq0), .irq_t1(irq1), .irq_t3(irq3)
    );

    // reference model, written from the requirements
    logic [31:0]       m_p = 0, m_t0 = 0;
    longint unsigned   m_pc = 0;
    logic [15:0]       m_c1 = 0;
    logic [29:0]       m_c3 = 0;
    logic              m_r1 = 0, m_e1 = 0, m_r3 = 0, m_e3 = 0;
    logic              m_i0 = 0, m_i1 = 0, m_i3 = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_p = 0; m_t0 = 0; m_pc = 0; m_c1 = 0; m_c3 = 0;
            m_r1 = 0; m_e1 = 0; m_r3 = 0; m_e3 = 0; m_i0 = 0; m_i1 = 0; m_i3 = 0;
        end else begin
            automatic bit st = (m_p != 0) && (m_pc == longint'(m_p) * CPU - 1);
            // R3 prescaler phase
            if ((wr && addr == 8'h88) || (wr && addr == 8'h90) || m_p == 0 || st) m_pc = 0;
            else m_pc = m_pc + 1;
            if (wr && addr == 8'h88) m_p = wdata;
            // R2 tick timer
            m_i0 = t60;
            if (wr && addr == 8'h8C) m_t0 = wdata;
            else if (t60) m_t0 = m_t0 + 1;
            // R4/R5 prescaled timer
            m_i1 = 0;
            if (wr && addr == 8'h90) begin
                m_c1 = wdata[15:0]; m_r1 = wdata[16]; m_e1 = 0;
            end else if (m_r1 && st) begin
                if (m_c1 <= 1) begin m_c1 = 0; m_r1 = 0; m_e1 = 1; m_i1 = 1; end
                else m_c1 = m_c1 - 1;
            end
            // R6/R7 fast timer
            m_i3 = 0;
            if (wr && addr == 8'hA8) begin
                m_c3 = wdata[29:0]; m_r3 = wdata[30]; m_e3 = 0;
            end else if (m_r3 && ft) begin
                if (m_c3 <= 1) begin m_c3 = 0; m_r3 = 0; m_e3 = 1; m_i3 = 1; end
                else m_c3 = m_c3 - 1;
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h88:   return m_p;
            8'h8C:   return m_t0;
            8'h90:   return {14'h0, m_e1, m_r1, m_c1};
            8'hA8:   return {m_e3, m_r3, m_c3};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h88:   return "R3";
            8'h8C:   return "R2";
            8'h90:   return "R4";
            8'hA8:   return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic auto_check();
        chk(tag_of(addr), rdata, m_read(addr));
        chk("R2 irq_tick", 32'(irq0), 32'(m_i0));
        chk("R5 irq_t1", 32'(irq1), 32'(m_i1));
        chk("R7 irq_t3", 32'(irq3), 32'(m_i3));
    endtask

    task automatic drive(input logic w, input logic [7:0] a, input logic [31:0] d,
                         input logic t, input logic f);
        @(negedge clk);
        if (chk_on) auto_check();
        wr = w; addr = a; wdata = d; t60 = t; ft = f;
    endtask

    task automatic wreg(input logic [7:0] a, input logic [31:0] d);
        drive(1'b1, a, d, 1'b0, 1'b0);
    endtask

    task automatic peek(input logic [7:0] a, input logic [31:0] exp, input string tag);
        drive(1'b0, a, 32'h0, 1'b0, 1'b0);
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1'b1;

        // R1 reset state
        peek(8'h88, 32'h0, "R1 presc");
        peek(8'h8C, 32'h0, "R1 tick");
        peek(8'h90, 32'h0, "R1 ptmr");
        peek(8'hA8, 32'h0, "R1 ftmr");
        chk("R1 irqs", {29'h0, irq0, irq1, irq3}, 32'h0);

        // R3/R5: P=1 -> 4 cycles per step, count 3 -> irq 12 cycles after the write edge
        wreg(8'h88, 32'h1);
        wreg(8'h90, 32'h0001_0003);
        begin
            int k = 0;
            for (int i = 1; i <= 40; i++) begin
                drive(1'b0, 8'h90, 32'h0, 1'b0, 1'b0);
                #1;
                if (irq1) begin k = i; break; end
            end
            chk("R3 R5 cycles to expiry", k, 13);
        end
        peek(8'h90, 32'h0002_0000, "R5 expired state");

        // R3: P=0 gives no steps
        wreg(8'h88, 32'h0);
        wreg(8'h90, 32'h0001_0002);
        repeat (40) drive(1'b0, 8'h90, 32'h0, 1'b0, 1'b0);
        peek(8'h90, 32'h0001_0002, "R3 no steps at P=0");

        // R4: upper bits read 0, expired cleared, running from bit 16
        wreg(8'h90, 32'hFFFF_FFFF);
        peek(8'h90, 32'h0001_FFFF, "R4 masked load");

        // R7: fast timer expiry after two strobes
        wreg(8'hA8, 32'h4000_0002);
        drive(1'b0, 8'hA8, 32'h0, 1'b0, 1'b1);
        drive(1'b0, 8'hA8, 32'h0, 1'b0, 1'b1);
        drive(1'b0, 8'hA8, 32'h0, 1'b0, 1'b0);
        #1;
        chk("R7 irq_t3 pulse", 32'(irq3), 32'h1);
        peek(8'hA8, 32'h8000_0000, "R7 expired state");

        // R6: write with start clear holds the count
        wreg(8'hA8, 32'h0001_2345);
        repeat (3) drive(1'b0, 8'hA8, 32'h0, 1'b0, 1'b1);
        peek(8'hA8, 32'h0001_2345, "R6 stopped timer");

        // R8: start from count 0 expires on first step
        wreg(8'hA8, 32'h4000_0000);
        drive(1'b0, 8'hA8, 32'h0, 1'b0, 1'b1);
        peek(8'hA8, 32'h8000_0000, "R8 zero-count start");

        // R10: write beats a simultaneous tick
        drive(1'b1, 8'h8C, 32'h0000_DEAD, 1'b1, 1'b0);
        peek(8'h8C, 32'h0000_DEAD, "R10 write wins");
        drive(1'b0, 8'h8C, 32'h0, 1'b1, 1'b0);
        drive(1'b0, 8'h8C, 32'h0, 1'b0, 1'b0);
        #1;
        chk("R2 tick pulse", 32'(irq0), 32'h1);
        chk("R2 tick count", rdata, 32'h0000_DEAE);

        // R9: unmapped offset
        wreg(8'h94, 32'hFFFF_FFFF);
        peek(8'h94, 32'h0, "R9 unmapped read");
        peek(8'h8C, 32'h0000_DEAE, "R9 no side effect");

        // seeded random traffic against the reference model
        void'($urandom(32'h5EED_0001));
        for (int n = 0; n < 4000; n++) begin
            automatic logic [7:0]  a;
            automatic logic [31:0] d;
            automatic int sel = $urandom_range(0, 4);
            case (sel)
                0: begin a = 8'h88; d = $urandom_range(0, 3); end
                1: begin a = 8'h8C; d = $urandom; end
                2: begin a = 8'h90; d = {$urandom} & 32'h0003_0007; end
                3: begin a = 8'hA8; d = {$urandom} & 32'hC000_000F; end
                default: begin a = 8'h94; d = $urandom; end
            endcase
            drive($urandom_range(0, 15) == 0, a, d,
                  $urandom_range(0, 7) == 0, $urandom_range(0, 1) == 1);
        end
        drive(1'b0, 8'h90, 32'h0, 1'b0, 1'b0);
        @(negedge clk);
        auto_check();

        done = 1'b1;
        finish_run();
    end
endmodule